// File: doc/BRIEF.md
# Timer Channel Event Flag Register

This block holds the three sticky event flags of one timer channel and presents them to the CPU as an 8-bit status register. The first flag marks a wrap of the 16-bit channel counter in either direction. The other two mark a compare match or input capture on channel register A and on channel register B. The block finds the wrap itself by comparing each counter value with the value it saw one cycle earlier. The two compare/capture events arrive as one-cycle pulses from the timer core.

Software clears a flag by a two-step handshake. It reads the register while the flag is 1, which arms that flag. It then writes 0 to the flag's bit. A write that is not preceded by such a read does not clear the flag, and a write of 1 never sets it. Each flag is combined with its bit of an external interrupt-enable vector to form an interrupt request. A standby input returns the register to its reset state, in the same way as reset.

Top module: `tsf_status_reg`

## Requirements
- R1: The read data places the register-A flag at bit 0, the register-B flag at bit 1 and the wrap flag at bit 2. Bits 7 down to 3 always read as 1.
- R2: After reset the read data is 0xF8 and all interrupt requests are 0.
- R3: A one-cycle pulse on `cmpa_evt_i` or `cmpb_evt_i` sets the matching flag at the next clock edge. The flag then stays set while no clearing write occurs.
- R4: A counter step from 0xFFFF to 0x0000 between two consecutive cycles sets the wrap flag (bit 2).
- R5: A counter step from 0x0000 to 0xFFFF sets the wrap flag. Any other change, or a counter that holds its value, leaves the wrap flag at 0.
- R6: A write of 0 to a set flag clears nothing unless a read since the last write returned that flag as 1. This includes a read that was made while the flag was still 0.
- R7: A read that returns a flag as 1, followed by a write with 0 in that bit, clears the flag. Flags written with 1 keep their value. Any write disarms all flags.
- R8: A write of 1 to a flag that is 0 leaves it at 0.
- R9: When a set event and an armed clearing write for the same flag fall in one cycle, the flag stays 1.
- R10: `irq_o[i]` is 1 exactly when flag i is 1 and `ien_i[i]` is 1. It changes in the same cycle as the flag, with no added delay.
- R11: A cycle with `stby_i` high returns the read data to 0xF8 and discards every armed state.
- R12: Writes to bits 7 down to 3 have no effect on the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stby_i | input | 1 | Standby: returns the register to its reset state |
| cnt_i | input | 16 | Current value of the channel counter |
| cmpa_evt_i | input | 1 | Compare/capture pulse for register A |
| cmpb_evt_i | input | 1 | Compare/capture pulse for register B |
| ien_i | input | 3 | Interrupt enables, same bit order as the flags |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_o | output | 3 | Interrupt requests, same bit order as the flags |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as a new set event for an armed flag. The stimulus first reads the flag as 1 to arm it. It then drives the write strobe with 0 in that bit together with the event pulse at the same falling edge, and checks that the flag survives. The arming rule is tested in the same way. A read is made while a flag is 0, the flag is then set by an event, and a later write of 0 must not clear it. A read made before standby must also not survive into the cycles after standby.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int FLAG_N  = 3;
  localparam int IDX_A   = 0;
  localparam int IDX_B   = 1;
  localparam int IDX_WRP = 2;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/tsf_reset_sync.sv
module tsf_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tsf_wrap_detect.sv
module tsf_wrap_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = {CNT_W{1'b0}};

  logic [CNT_W-1:0] prev_q, prev_d;
  logic             valid_q, valid_d;
  logic             up_wrap, down_wrap;

  always_comb begin
    prev_d  = cnt_i;
    valid_d = 1'b1;
    if (stby_i) begin
      prev_d  = CNT_MIN;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= CNT_MIN;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      valid_q <= valid_d;
    end
  end

  assign up_wrap   = (prev_q == CNT_MAX) && (cnt_i == CNT_MIN);
  assign down_wrap = (prev_q == CNT_MIN) && (cnt_i == CNT_MAX);
  assign wrap_o    = valid_q && (up_wrap || down_wrap);
endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic upd_en;

  assign upd_en = stby_i | set_i | rd_i | wr_i;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (stby_i) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end else begin
      if (wr_i)                 armed_d = 1'b0;
      else if (rd_i && flag_q)  armed_d = 1'b1;
      if (set_i)                            flag_d = 1'b1;
      else if (wr_i && armed_q && !wbit_i)  flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/tsf_status_reg.sv
module tsf_status_reg
  import tsf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cmpa_evt_i,
  input  logic              cmpb_evt_i,
  input  logic [FLAG_N-1:0] ien_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FLAG_N-1:0] irq_o
);
  localparam int RSV_W = DATA_W - FLAG_N;

  logic      rst_sync_n;
  logic      wrap_evt;
  flag_vec_t set_vec, flag_vec, armed_vec;
  logic      unused_wdata_hi;

  tsf_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tsf_wrap_detect #(.CNT_W(CNT_W)) u_wrap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stby_i (stby_i),
    .cnt_i  (cnt_i),
    .wrap_o (wrap_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_A]   = cmpa_evt_i;
    set_vec[IDX_B]   = cmpb_evt_i;
    set_vec[IDX_WRP] = wrap_evt;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    tsf_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .stby_i  (stby_i),
      .set_i   (set_vec[i]),
      .rd_i    (rd_en_i),
      .wr_i    (wr_en_i),
      .wbit_i  (wdata_i[i]),
      .flag_o  (flag_vec[i]),
      .armed_o (armed_vec[i])
    );
  end

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:FLAG_N];
  assign rdata_o         = {{RSV_W{1'b1}}, flag_vec};
  assign irq_o           = flag_vec & ien_i;
endmodule

// File: rtl/tsf_status_reg_chk.sv
module tsf_status_reg_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       stby_i,
  input logic       cmpa_evt_i,
  input logic       cmpb_evt_i,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic [2:0] armed_vec,
  input logic [7:0] rdata_o,
  input logic [2:0] irq_o
);
  // R1
  reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdata_o[7:3] == 5'b11111);

  // R3
  set_a_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmpa_evt_i && !stby_i) |=> rdata_o[0]);

  // R6
  blind_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && !armed_vec[1] && rdata_o[1] && !stby_i) |=> rdata_o[1]);

  // R8
  write_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && wdata_i[0] && !rdata_o[0] && !cmpa_evt_i) |=> !rdata_o[0]);

  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmpb_evt_i && wr_en_i && !stby_i) |=> rdata_o[1]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o & ~rdata_o[2:0]) == 3'b000);

  // R11
  standby_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stby_i |=> (rdata_o == 8'hF8 && armed_vec == 3'b000));
endmodule

bind tsf_status_reg tsf_status_reg_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .stby_i     (stby_i),
  .cmpa_evt_i (cmpa_evt_i),
  .cmpb_evt_i (cmpb_evt_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .armed_vec  (armed_vec),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o)
);

// File: tb/tsf_status_reg_test.sv
module tsf_status_reg_test;
  logic        clk;
  logic        rst_n;
  logic        stby_i;
  logic [15:0] cnt_i;
  logic        cmpa_evt_i, cmpb_evt_i;
  logic [2:0]  ien_i;
  logic        rd_en_i, wr_en_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic [2:0]  irq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  tsf_status_reg uut (
    .clk(clk), .rst_n(rst_n), .stby_i(stby_i), .cnt_i(cnt_i),
    .cmpa_evt_i(cmpa_evt_i), .cmpb_evt_i(cmpb_evt_i), .ien_i(ien_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_en_i = 1'b1; step(); rd_en_i = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en_i = 1'b1; wdata_i = d; step(); wr_en_i = 1'b0; wdata_i = 8'h00;
  endtask

  task automatic pulse_a();
    cmpa_evt_i = 1'b1; step(); cmpa_evt_i = 1'b0;
  endtask

  task automatic pulse_b();
    cmpb_evt_i = 1'b1; step(); cmpb_evt_i = 1'b0;
  endtask

  task automatic clear_all();
    do_read(); do_write(8'h00);
  endtask

  task automatic t_reset();
    chk("R2 reset rdata", rdata_o, 8'hF8);
    chk("R2 reset irq", {5'd0, irq_o}, 8'h00);
  endtask

  task automatic t_layout();
    pulse_a();
    chk("R1 A at bit0", rdata_o, 8'hF9);
    pulse_b();
    chk("R1 B at bit1", rdata_o, 8'hFB);
    clear_all();
    chk("R7 clear both", rdata_o, 8'hF8);
    do_write(8'hF8);
    chk("R12 high bits write ignored", rdata_o, 8'hF8);
    do_write(8'h00);
    chk("R12 high bits zero write ignored", rdata_o, 8'hF8);
  endtask

  task automatic t_sticky();
    pulse_b();
    step(); step(); step();
    chk("R3 B sticky", rdata_o, 8'hFA);
    clear_all();
  endtask

  task automatic t_up_wrap();
    cnt_i = 16'hFFFE; step();
    cnt_i = 16'hFFFF; step();
    chk("R5 FFFE->FFFF no wrap", rdata_o, 8'hF8);
    cnt_i = 16'h0000; step();
    chk("R4 up wrap", rdata_o, 8'hFC);
    clear_all();
  endtask

  task automatic t_down_wrap();
    cnt_i = 16'h0000; step(); step();
    chk("R5 held zero no wrap", rdata_o, 8'hF8);
    cnt_i = 16'hFFFF; step();
    chk("R5 down wrap", rdata_o, 8'hFC);
    clear_all();
    cnt_i = 16'h1234; step();
    cnt_i = 16'h0000; step();
    chk("R5 1234->0000 no wrap", rdata_o, 8'hF8);
  endtask

  task automatic t_blind();
    pulse_a();
    do_write(8'h00);
    chk("R6 blind write keeps flag", rdata_o, 8'hF9);
    clear_all();
    do_read();
    pulse_a();
    do_write(8'h00);
    chk("R6 read-while-0 does not arm", rdata_o, 8'hF9);
    clear_all();
  endtask

  task automatic t_selective();
    pulse_a(); pulse_b();
    do_read();
    do_write(8'h01);
    chk("R7 only zero bit clears", rdata_o, 8'hF9);
    do_write(8'h00);
    chk("R7 write disarms", rdata_o, 8'hF9);
    clear_all();
    chk("R7 rearm and clear", rdata_o, 8'hF8);
  endtask

  task automatic t_write_one();
    do_write(8'hFF);
    chk("R8 write ones sets nothing", rdata_o, 8'hF8);
  endtask

  task automatic t_collide();
    pulse_b();
    do_read();
    cmpb_evt_i = 1'b1; wr_en_i = 1'b1; wdata_i = 8'h00;
    step();
    cmpb_evt_i = 1'b0; wr_en_i = 1'b0;
    chk("R9 set beats clear", rdata_o, 8'hFA);
    do_write(8'h00);
    chk("R9 arm consumed", rdata_o, 8'hFA);
    clear_all();
  endtask

  task automatic t_irq();
    ien_i = 3'b101;
    pulse_a();
    chk("R10 irq A same cycle", {5'd0, irq_o}, 8'h01);
    pulse_b();
    chk("R10 irq B masked", {5'd0, irq_o}, 8'h01);
    ien_i = 3'b010; #1;
    chk("R10 enable swap", {5'd0, irq_o}, 8'h02);
    clear_all();
    chk("R10 irq drops with flag", {5'd0, irq_o}, 8'h00);
    ien_i = 3'b000;
  endtask

  task automatic t_standby();
    pulse_a(); pulse_b();
    do_read();
    stby_i = 1'b1; step(); stby_i = 1'b0;
    chk("R11 standby value", rdata_o, 8'hF8);
    pulse_a();
    do_write(8'h00);
    chk("R11 standby disarms", rdata_o, 8'hF9);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; stby_i = 1'b0; cnt_i = 16'h0000;
    cmpa_evt_i = 1'b0; cmpb_evt_i = 1'b0; ien_i = 3'b000;
    rd_en_i = 1'b0; wr_en_i = 1'b0; wdata_i = 8'h00;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    t_reset();
    t_layout();
    t_sticky();
    t_up_wrap();
    t_down_wrap();
    t_blind();
    t_selective();
    t_write_one();
    t_collide();
    t_irq();
    t_standby();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule